// File: doc/BRIEF.md
# Threshold FIFO Pair with Interrupt Unit

This block holds a transmit and a receive byte queue between a register port and a serial transaction engine. Software pushes transmit bytes through one register and pops receive bytes through another. The engine drains the transmit queue and fills the receive queue through a simple valid/pop and ready/push pair. Each queue has a programmable threshold that raises a watermark flag. The transmit flag warns software to refill the queue, and the receive flag tells software to drain it.

All queue levels and engine events appear as bits of one raw status word at fixed positions. A mask register selects which of these bits reach a masked view. The single interrupt line is the OR of that masked view. Event bits are sticky and are cleared by writing ones to a clear register. Level bits always follow the queues. Either queue can be flushed through a control register. A flush takes a fixed number of cycles, and its control bit reads back as 1 until the flush is over.

Top module: `xfi_hub`

## Requirements
- R1: Bytes written to register index 1 (transmit data) leave at `eng_tx_data` in write order, one per `eng_tx_pop`, and up to 16 bytes are held.
- R2: Bytes pushed by the engine are returned in push order by reads of register index 2 (receive data). A read of an empty receive queue returns 0 and leaves the read position unchanged.
- R3: A transmit data write while the transmit queue holds 16 bytes is discarded, and it sets sticky raw bit 3 (overrun).
- R4: Raw bits 0 and 2 show transmit empty and transmit full. Raw bits 4 and 6 show receive empty and receive full.
- R5: Raw bit 1 is set while the transmit level is less than or equal to the 4-bit threshold in register index 3 (reset 0).
- R6: Raw bit 5 is set while the receive level is greater than or equal to the 4-bit threshold in register index 4 (reset 0).
- R7: Writing 1 to bit 0 (transmit) or bit 1 (receive) of register index 0 starts a flush of that queue. The bit reads 1 for FLUSH_CYCLES cycles and then 0, and the queue is then empty. Queue accesses made during the flush are ignored.
- R8: The inputs for done with stop, arbitration lost, bus error and done without stop set sticky raw bits 19, 24, 25 and 28 one cycle later. A write of ones to register index 8 (clear) removes sticky bits, and it leaves level bits unchanged.
- R9: When an event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R10: Register index 5 holds the mask, with bits 31:29 reading 0. Register index 7 reads raw AND mask, and `irq` is the OR of that word. Register index 6 reads the raw word.
- R11: After reset both queues are empty, both thresholds and the mask are 0, the raw word is 0x33 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on receive data index) |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| eng_tx_pop | input | 1 | Engine takes the transmit head byte |
| eng_tx_valid | output | 1 | Transmit queue has a byte and no flush is running |
| eng_tx_data | output | 8 | Transmit head byte |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_rx_ready | output | 1 | Receive queue has room and no flush is running |
| ev_done_stop | input | 1 | Transaction finished with a stop |
| ev_done_nostop | input | 1 | Transaction finished without a stop |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_bus_err | input | 1 | Bus error |
| irq | output | 1 | Combined interrupt |

## Verification
A sticky event and a software clear of the same bit can arrive in the same cycle. The bench drives a bus-error pulse in the cycle in which the clear register is written with bit 25 set, and it expects bit 25 to read as set afterwards. A second collision is a transmit data write in the middle of a flush. The bench checks through the engine port that the byte never appears and that the queue is empty once the control bit drops.

// File: rtl/xfi_pkg.sv
package xfi_pkg;

    localparam int REG_W = 32;
    localparam int ADDR_W = 4;

    // Register indices
    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 4'd0,
        A_TXDAT  = 4'd1,
        A_RXDAT  = 4'd2,
        A_TXTHR  = 4'd3,
        A_RXTHR  = 4'd4,
        A_MASK   = 4'd5,
        A_RAW    = 4'd6,
        A_MASKED = 4'd7,
        A_CLEAR  = 4'd8
    } reg_idx_e;

    // Status bit positions (software decodes these)
    localparam int B_TXE   = 0;
    localparam int B_TXNE  = 1;
    localparam int B_TXF   = 2;
    localparam int B_TXOVR = 3;
    localparam int B_RXE   = 4;
    localparam int B_RXNF  = 5;
    localparam int B_RXF   = 6;
    localparam int B_DONE  = 19;
    localparam int B_ARB   = 24;
    localparam int B_BERR  = 25;
    localparam int B_DONEN = 28;

    localparam logic [REG_W-1:0] LIVE_BITS = 32'h1FFF_FFFF;

    typedef struct packed {
        logic tx_empty;
        logic tx_low;
        logic tx_full;
        logic rx_empty;
        logic rx_high;
        logic rx_full;
    } lvl_t;

    typedef struct packed {
        logic tx_ovr;
        logic done_stop;
        logic arb_lost;
        logic bus_err;
        logic done_nostop;
    } evt_t;

    function automatic logic [REG_W-1:0] lvl_word(input lvl_t l);
        logic [REG_W-1:0] w;
        w = '0;
        w[B_TXE]  = l.tx_empty;
        w[B_TXNE] = l.tx_low;
        w[B_TXF]  = l.tx_full;
        w[B_RXE]  = l.rx_empty;
        w[B_RXNF] = l.rx_high;
        w[B_RXF]  = l.rx_full;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] evt_word(input evt_t e);
        logic [REG_W-1:0] w;
        w = '0;
        w[B_TXOVR] = e.tx_ovr;
        w[B_DONE]  = e.done_stop;
        w[B_ARB]   = e.arb_lost;
        w[B_BERR]  = e.bus_err;
        w[B_DONEN] = e.done_nostop;
        return w;
    endfunction

    localparam logic [REG_W-1:0] STICKY_BITS =
        (32'h1 << B_TXOVR) | (32'h1 << B_DONE) | (32'h1 << B_ARB) |
        (32'h1 << B_BERR) | (32'h1 << B_DONEN);

endpackage

// File: rtl/xfi_byte_fifo.sv
module xfi_byte_fifo #(
    parameter int DEPTH        = 16,
    parameter int FLUSH_CYCLES = 4,
    parameter int CW           = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          pop,
    output logic [7:0]    head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    input  logic          flush_start,
    output logic          flush_busy,
    output logic          push_drop
);
    localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int FCW = (FLUSH_CYCLES > 1) ? $clog2(FLUSH_CYCLES) : 1;

    logic [7:0]     mem [DEPTH];
    logic [AW-1:0]  wp, rp;
    logic [CW-1:0]  cnt;
    logic           busy;
    logic [FCW-1:0] fcnt;
    logic           do_push, do_pop;

    assign full       = (cnt == CW'(DEPTH));
    assign empty      = (cnt == '0);
    assign count      = cnt;
    assign flush_busy = busy;
    assign do_push    = push && !busy && !full;
    assign do_pop     = pop && !busy && !empty;
    assign push_drop  = push && !busy && full;
    assign head       = empty ? 8'h00 : mem[rp];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp   <= '0;
            rp   <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            fcnt <= '0;
        end else if (busy) begin
            if (fcnt == '0) begin
                busy <= 1'b0;
                wp   <= '0;
                rp   <= '0;
                cnt  <= '0;
            end else begin
                fcnt <= fcnt - FCW'(1);
            end
        end else if (flush_start) begin
            busy <= 1'b1;
            fcnt <= FCW'(FLUSH_CYCLES - 1);
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    // R3: a push into a full queue leaves the level untouched
    p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !busy && !flush_start) |=> (count == $past(count)));

    // R2: a pop of an empty queue leaves it empty
    p_empty_pop_r2: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push && !busy && !flush_start) |=> empty);

    // R7: the queue is empty when the flush ends
    p_flush_end_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(flush_busy) |-> empty);

    // R7: no access moves the level while a flush runs
    p_flush_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        (flush_busy && $past(flush_busy)) |-> ($stable(count) || empty));

endmodule

// File: rtl/xfi_irq_unit.sv
module xfi_irq_unit
    import xfi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  lvl_t             lvl,
    input  evt_t             evt,
    input  logic             mask_we,
    input  logic             clr_we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] raw,
    output logic [REG_W-1:0] mask,
    output logic [REG_W-1:0] masked,
    output logic             irq
);
    logic [REG_W-1:0] sticky_q, mask_q, clr_bits, set_bits;

    assign clr_bits = clr_we ? (wdata & STICKY_BITS) : '0;
    assign set_bits = evt_word(evt);

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky_q <= '0;
            mask_q   <= '0;
        end else begin
            // a new event wins over a clear in the same cycle
            sticky_q <= (sticky_q & ~clr_bits) | set_bits;
            if (mask_we) mask_q <= wdata & LIVE_BITS;
        end
    end

    assign raw    = lvl_word(lvl) | sticky_q;
    assign mask   = mask_q;
    assign masked = raw & mask_q;
    assign irq    = |masked;

    // R8: arbitration loss shows up one cycle later
    p_arb_sets_r8: assert property (@(posedge clk) disable iff (rst)
        evt.arb_lost |=> raw[B_ARB]);

    // R8: sticky bits only fall on a clear write
    p_sticky_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !clr_we |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

    // R9: event and clear together leave the bit set
    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (evt.bus_err && clr_we && wdata[B_BERR]) |=> raw[B_BERR]);

    // R10: interrupt only with an enabled bit
    p_irq_mask_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (mask != '0));

endmodule

// File: rtl/xfi_hub.sv
module xfi_hub
    import xfi_pkg::*;
#(
    parameter int DEPTH        = 16,
    parameter int FLUSH_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        eng_tx_pop,
    output logic        eng_tx_valid,
    output logic [7:0]  eng_tx_data,
    input  logic        eng_rx_push,
    input  logic [7:0]  eng_rx_data,
    output logic        eng_rx_ready,
    input  logic        ev_done_stop,
    input  logic        ev_done_nostop,
    input  logic        ev_arb_lost,
    input  logic        ev_bus_err,
    output logic        irq
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int TW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [TW-1:0] tx_thr, rx_thr;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic          tx_busy, rx_busy, tx_drop, rx_drop_unused;
    logic [7:0]    rx_head;
    logic          wr_ctrl, wr_tx, rd_rx;
    lvl_t          lvl;
    evt_t          evt;
    logic [31:0]   raw, mask, masked;

    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign wr_tx   = reg_wr && (reg_addr == A_TXDAT);
    assign rd_rx   = reg_rd && (reg_addr == A_RXDAT);

    xfi_byte_fifo #(.DEPTH(DEPTH), .FLUSH_CYCLES(FLUSH_CYCLES), .CW(CW)) u_txq (
        .clk(clk), .rst(rst),
        .push(wr_tx), .push_data(reg_wdata[7:0]),
        .pop(eng_tx_pop), .head(eng_tx_data),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty),
        .flush_start(wr_ctrl && reg_wdata[0]), .flush_busy(tx_busy),
        .push_drop(tx_drop)
    );

    xfi_byte_fifo #(.DEPTH(DEPTH), .FLUSH_CYCLES(FLUSH_CYCLES), .CW(CW)) u_rxq (
        .clk(clk), .rst(rst),
        .push(eng_rx_push), .push_data(eng_rx_data),
        .pop(rd_rx), .head(rx_head),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty),
        .flush_start(wr_ctrl && reg_wdata[1]), .flush_busy(rx_busy),
        .push_drop(rx_drop_unused)
    );

    assign eng_tx_valid = !tx_empty && !tx_busy;
    assign eng_rx_ready = !rx_full && !rx_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_thr <= '0;
            rx_thr <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_TXTHR) tx_thr <= reg_wdata[TW-1:0];
            if (reg_addr == A_RXTHR) rx_thr <= reg_wdata[TW-1:0];
        end
    end

    always_comb begin
        lvl.tx_empty = tx_empty;
        lvl.tx_low   = (tx_cnt <= CW'(tx_thr));
        lvl.tx_full  = tx_full;
        lvl.rx_empty = rx_empty;
        lvl.rx_high  = (rx_cnt >= CW'(rx_thr));
        lvl.rx_full  = rx_full;
        evt.tx_ovr      = tx_drop;
        evt.done_stop   = ev_done_stop;
        evt.arb_lost    = ev_arb_lost;
        evt.bus_err     = ev_bus_err;
        evt.done_nostop = ev_done_nostop;
    end

    xfi_irq_unit u_irq (
        .clk(clk), .rst(rst), .lvl(lvl), .evt(evt),
        .mask_we(reg_wr && (reg_addr == A_MASK)),
        .clr_we(reg_wr && (reg_addr == A_CLEAR)),
        .wdata(reg_wdata),
        .raw(raw), .mask(mask), .masked(masked), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:   reg_rdata = {30'd0, rx_busy, tx_busy};
            A_RXDAT:  reg_rdata = rx_busy ? 32'd0 : {24'd0, rx_head};
            A_TXTHR:  reg_rdata = 32'(tx_thr);
            A_RXTHR:  reg_rdata = 32'(rx_thr);
            A_MASK:   reg_rdata = mask;
            A_RAW:    reg_rdata = raw;
            A_MASKED: reg_rdata = masked;
            default:  reg_rdata = '0;
        endcase
    end

    // R2: reading an empty receive queue yields zero
    p_empty_read_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_rx && rx_empty) |-> (reg_rdata == 32'd0));

    // R1: the engine never sees a byte while the transmit flush runs
    p_tx_flush_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        tx_busy |-> !eng_tx_valid);

endmodule

// File: tb/xfi_hub_test.sv
`timescale 1ns/1ps
module xfi_hub_test;
    localparam int DEPTH = 16;
    localparam int FLUSH_CYCLES = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 0, reg_rd = 0;
    logic [3:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        eng_tx_pop = 0, eng_tx_valid;
    logic [7:0]  eng_tx_data;
    logic        eng_rx_push = 0, eng_rx_ready;
    logic [7:0]  eng_rx_data = 0;
    logic        ev_done_stop = 0, ev_done_nostop = 0, ev_arb_lost = 0, ev_bus_err = 0;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    always #2 clk = ~clk;

    xfi_hub #(.DEPTH(DEPTH), .FLUSH_CYCLES(FLUSH_CYCLES)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_tx_pop(eng_tx_pop),
        .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data), .eng_rx_push(eng_rx_push),
        .eng_rx_data(eng_rx_data), .eng_rx_ready(eng_rx_ready), .ev_done_stop(ev_done_stop),
        .ev_done_nostop(ev_done_nostop), .ev_arb_lost(ev_arb_lost), .ev_bus_err(ev_bus_err),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1 reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
        @(posedge clk); #1 reg_rd = 0;
    endtask

    // driver: transmit byte goes to the scoreboard as it is written
    task automatic tx_put(input logic [7:0] b);
        wr(4'd1, {24'd0, b});
        txq.push_back(b);
    endtask

    // monitor: engine-side pop compared with the scoreboard head
    task automatic tx_take(input string req);
        logic [7:0] e;
        @(negedge clk);
        e = (txq.size() > 0) ? txq.pop_front() : 8'hxx;
        chk({req, " engine valid"}, {31'd0, eng_tx_valid}, 32'd1);
        chk({req, " engine byte"}, {24'd0, eng_tx_data}, {24'd0, e});
        eng_tx_pop = 1;
        @(posedge clk); #1 eng_tx_pop = 0;
    endtask

    task automatic rx_put(input logic [7:0] b);
        @(negedge clk); eng_rx_push = 1; eng_rx_data = b;
        @(posedge clk); #1 eng_rx_push = 0;
        rxq.push_back(b);
    endtask

    task automatic rx_take(input string req);
        logic [31:0] v;
        logic [7:0] e;
        e = rxq.pop_front();
        rd(4'd2, v);
        chk(req, v, {24'd0, e});
    endtask

    task automatic raw_bit(input string req, input int b, input logic e);
        logic [31:0] v;
        rd(4'd6, v);
        chk(req, {31'd0, v[b]}, {31'd0, e});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R11 reset state
        rd(4'd6, v); chk("R11 raw", v, 32'h33);
        chk("R11 irq", {31'd0, irq}, 0);
        rd(4'd5, v); chk("R11 mask", v, 0);
        rd(4'd3, v); chk("R11 tx threshold", v, 0);

        // R5 transmit watermark, R1 order, R4 full, R3 overrun
        wr(4'd3, 32'd2);
        tx_put(8'h10); raw_bit("R5 level1 low", 1, 1); raw_bit("R4 tx not empty", 0, 0);
        tx_put(8'h11); raw_bit("R5 level2 low", 1, 1);
        tx_put(8'h12); raw_bit("R5 level3 not low", 1, 0);
        for (int i = 3; i < DEPTH; i++) tx_put(8'h10 + 8'(i));
        raw_bit("R4 tx full", 2, 1);
        raw_bit("R3 no overrun yet", 3, 0);
        wr(4'd1, 32'hEE);   // discarded
        raw_bit("R3 overrun set", 3, 1);
        for (int i = 0; i < DEPTH; i++) tx_take("R1");
        chk("R3 dropped byte absent", {31'd0, eng_tx_valid}, 0);
        raw_bit("R4 tx empty", 0, 1);
        raw_bit("R3 overrun sticky", 3, 1);
        wr(4'd8, 32'h0000_0009);
        raw_bit("R8 overrun cleared", 3, 0);
        raw_bit("R8 level bit kept", 0, 1);

        // R6 receive watermark, R4 receive full, R2 order and empty read
        wr(4'd4, 32'd3);
        rx_put(8'hA0); rx_put(8'hA1);
        raw_bit("R6 level2 not high", 5, 0);
        raw_bit("R4 rx not empty", 4, 0);
        rx_put(8'hA2);
        raw_bit("R6 level3 high", 5, 1);
        for (int i = 3; i < DEPTH; i++) rx_put(8'hA0 + 8'(i));
        raw_bit("R4 rx full", 6, 1);
        chk("R4 engine not ready when full", {31'd0, eng_rx_ready}, 0);
        for (int i = 0; i < DEPTH; i++) rx_take("R2 order");
        rd(4'd2, v); chk("R2 empty read zero", v, 0);
        rx_put(8'h5A);
        rx_take("R2 pointer kept");

        // R7 flush of transmit queue with a write during the flush
        for (int i = 0; i < 5; i++) tx_put(8'h30 + 8'(i));
        wr(4'd0, 32'h1);
        txq.delete();
        rd(4'd0, v); chk("R7 flush busy", v, 32'h1);
        wr(4'd1, 32'h77);   // ignored during flush
        repeat (FLUSH_CYCLES + 2) @(posedge clk);
        rd(4'd0, v); chk("R7 flush done", v, 32'h0);
        raw_bit("R7 tx empty after flush", 0, 1);
        chk("R7 nothing offered", {31'd0, eng_tx_valid}, 0);
        tx_put(8'h42);
        tx_take("R7 write after flush");

        // R7 receive flush
        rx_put(8'h01); rx_put(8'h02);
        wr(4'd0, 32'h2);
        rd(4'd0, v); chk("R7 rx flush busy", v, 32'h2);
        repeat (FLUSH_CYCLES + 2) @(posedge clk);
        rxq.delete();
        raw_bit("R7 rx empty after flush", 4, 1);
        rd(4'd2, v); chk("R7 rx read after flush", v, 0);

        // R8 events, R10 masking
        @(negedge clk); ev_arb_lost = 1; @(posedge clk); #1 ev_arb_lost = 0;
        raw_bit("R8 arbitration bit", 24, 1);
        chk("R10 irq masked off", {31'd0, irq}, 0);
        wr(4'd5, 32'h0100_0000);
        #1 chk("R10 irq on", {31'd0, irq}, 1);
        rd(4'd7, v); chk("R10 masked view", v, 32'h0100_0000);
        wr(4'd8, 32'h0100_0000);
        #1 chk("R8 irq after clear", {31'd0, irq}, 0);
        raw_bit("R8 arbitration cleared", 24, 0);
        @(negedge clk); ev_done_stop = 1; ev_done_nostop = 1;
        @(posedge clk); #1 ev_done_stop = 0; ev_done_nostop = 0;
        raw_bit("R8 done with stop", 19, 1);
        raw_bit("R8 done without stop", 28, 1);

        // R9 same-cycle event and clear
        @(negedge clk); ev_bus_err = 1; reg_wr = 1; reg_addr = 4'd8; reg_wdata = 32'h1208_0000;
        @(posedge clk); #1 ev_bus_err = 0; reg_wr = 0;
        raw_bit("R9 set wins", 25, 1);
        raw_bit("R9 other bit cleared", 19, 0);

        // R10 reserved mask bits
        wr(4'd5, 32'hFFFF_FFFF);
        rd(4'd5, v); chk("R10 mask reserved", v, 32'h1FFF_FFFF);
        rd(4'd6, v);
        begin
            logic [31:0] m;
            rd(4'd7, m); chk("R10 masked equals raw", m, v);
        end
        chk("R10 irq any", {31'd0, irq}, 1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule